// File: doc/BRIEF.md
# Thermal Trip Supervisor

This block watches up to four on-die temperature sensors without software help. Once auto mode is on, it walks the enabled channels in a fixed order at a programmable rate. For each channel it sends a sample request to an external converter, takes the returned code and stores it in a read-only data register. It then compares the code with two limits for that channel. The converter's code gets smaller as the die gets hotter, so a channel is over a limit when its code is at or below that limit.

The shutdown limit uses a debounce count: only a run of consecutive over-limit samples trips the channel. A tripped channel can be routed to two places. The first is a one-cycle shutdown pulse toward the reset and clock controller. The second is an external shutdown pin with selectable polarity, which stays asserted until reset. The second, lower-priority limit also has a debounce count. When it is met, the channel is marked hot, and while any channel is hot the supervisor samples at a separate, faster period.

A sticky status flag records that a routed trip occurred. A system reset leaves it intact, so boot code can see why the chip restarted. Only a power-on reset or a write of one clears it. Software sets the block up through a small word-addressed register bus with same-cycle read data. A `tick` strobe from an external divider sets the sampling time base.

Top module: `thermtrip_monitor`

## Requirements
- R1: After power-on reset every register reads 0, `cru_shut` is 0 and `shut_pin` is 1 (inactive, active-low by default).
- R2: Register map (word offsets, byte address). 0x04 control: bit 0 auto enable, bits 7:4 channel enables, bit 8 pin polarity (1 = active-high), bit 24 last-trip flag. 0x08 routing: bits 7:4 send channels 0..3 to the pin, bits 11:8 send them to the controller pulse. 0x30+4i is the hot limit and 0x40+4i the shutdown limit of channel i (12 bits). 0x60 is the hot debounce and 0x64 the shutdown debounce (8 bits). 0x68 is the normal period and 0x6C the hot period (16 bits). All of these read back what was written.
- R3: Offsets outside the map, and unaligned byte addresses, read 0 and ignore writes. The data registers at 0x20+4i read the last sampled code of channel i and ignore writes.
- R4: Within a round, enabled channels are requested in ascending index order. Disabled channels are skipped and their data registers keep their value. Each request holds `adc_req` and `adc_ch` until `adc_ack`.
- R5: A sample is over the shutdown limit when its code is less than or equal to that limit. For example, 3421 trips against 3437, 3437 trips against 3437, and 3438 does not.
- R6: A channel trips on its Nth consecutive over-limit sample, where N is the shutdown debounce (0 acts as 1). A sample above the limit restarts the run. A channel trips at most once until reset.
- R7: With `tick` high every cycle and one channel enabled, consecutive requests start period+1 cycles apart.
- R8: After hot-debounce consecutive samples at or below its hot limit, a channel is hot, and rounds then use the hot period (gap hot-period+1). One sample above the hot limit makes it no longer hot.
- R9: A trip of channel i gives exactly one `cru_shut` pulse of one cycle if routing bit 8+i is set, and none otherwise.
- R10: A trip of channel i asserts `shut_pin` if routing bit 4+i is set, and the pin stays asserted until `rst_n`. The asserted level is 0, or 1 when control bit 8 is set. The pin holds its inactive level while no routed trip has occurred.
- R11: A routed trip sets control bit 24. A low `rst_n` does not clear it. A low `por_n` clears it, and so does writing 1 to bit 24.
- R12: While control bit 0 is 0, no sample is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset (keeps last-trip flag) |
| por_n | input | 1 | Synchronous active-low power-on reset (clears last-trip flag) |
| tick | input | 1 | Sampling time-base strobe |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| adc_req | output | 1 | Sample request, held until acknowledged |
| adc_ch | output | 2 | Channel being requested |
| adc_ack | input | 1 | Converter returns a code this cycle |
| adc_code | input | 12 | Converter code, valid with `adc_ack` |
| cru_shut | output | 1 | One-cycle shutdown pulse to reset/clock control |
| shut_pin | output | 1 | External shutdown pin, programmable polarity |

## Verification
A bad debounce counter shows up as a pin or pulse change one sample too early or too late. So the bench checks the outputs after every single converter acknowledge in a debounce run, not only at the end. A wrong channel walk appears at once in the `adc_ch` sequence and in data registers that should have stayed untouched. A wrong hot state shows up as a change in the request-to-request gap within one round. A lost or wrongly reset sticky flag is visible in the first control read after a system reset.

// File: rtl/tt_pkg.sv
// Package: shared constants for the thermal trip supervisor.
// Assumes a fixed count of four sensor channels, because the register
// fields place one bit per channel at fixed positions.
package tt_pkg;
    localparam int NCH = 4;

    // word indexes (byte address / 4) of the register map
    localparam int W_CTRL    = 1;
    localparam int W_ROUTE   = 2;
    localparam int W_DATA    = 8;
    localparam int W_HOT     = 12;
    localparam int W_SHUT    = 16;
    localparam int W_HOT_DBC = 24;
    localparam int W_SHT_DBC = 25;
    localparam int W_PER     = 26;
    localparam int W_PER_HOT = 27;

    // field positions inside the control and routing words
    localparam int B_AUTO   = 0;
    localparam int B_SRC    = 4;
    localparam int B_POL    = 8;
    localparam int B_LAST   = 24;
    localparam int B_PINRT  = 4;
    localparam int B_CRURT  = 8;

    typedef enum logic [0:0] {
        SCH_IDLE = 1'b0,
        SCH_REQ  = 1'b1
    } sched_state_e;
endpackage

// File: rtl/tt_regs.sv
// Module: register file of the supervisor.
// Holds configuration, per-channel limits and sampled codes, plus the
// sticky last-trip flag that only power-on reset or a write of one clears.
// Assumes word-aligned accesses; unaligned or unmapped addresses are inert.
module tt_regs
    import tt_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int DBC_W  = 8,
    parameter int PER_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        por_n,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [7:0]                  bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    input  logic                        smp_vld,
    input  logic [1:0]                  smp_ch,
    input  logic [CODE_W-1:0]           smp_code,
    input  logic                        trip_log,
    output logic                        auto_en,
    output logic [NCH-1:0]              src_en,
    output logic                        pol,
    output logic [NCH-1:0]              pin_route,
    output logic [NCH-1:0]              cru_route,
    output logic [NCH-1:0][CODE_W-1:0]  hot_thr,
    output logic [NCH-1:0][CODE_W-1:0]  shut_thr,
    output logic [DBC_W-1:0]            hot_dbc,
    output logic [DBC_W-1:0]            shut_dbc,
    output logic [PER_W-1:0]            period,
    output logic [PER_W-1:0]            period_hot,
    output logic                        last_flag
);
    localparam int CPAD = 32 - CODE_W;
    localparam int DPAD = 32 - DBC_W;
    localparam int PPAD = 32 - PER_W;

    logic [5:0]                  widx;
    logic                        aligned;
    logic                        wr_en;
    logic [NCH-1:0][CODE_W-1:0]  data_q;
    logic                        unused_wbits;

    assign widx         = bus_addr[7:2];
    assign aligned      = (bus_addr[1:0] == 2'b00);
    assign wr_en        = bus_sel & bus_wr & aligned;
    assign unused_wbits = ^bus_wdata;

    // global control, routing, debounce and period registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_en    <= 1'b0;
            src_en     <= '0;
            pol        <= 1'b0;
            pin_route  <= '0;
            cru_route  <= '0;
            hot_dbc    <= '0;
            shut_dbc   <= '0;
            period     <= '0;
            period_hot <= '0;
        end else if (wr_en) begin
            case (int'(widx))
                W_CTRL: begin
                    auto_en <= bus_wdata[B_AUTO];
                    src_en  <= bus_wdata[B_SRC +: NCH];
                    pol     <= bus_wdata[B_POL];
                end
                W_ROUTE: begin
                    pin_route <= bus_wdata[B_PINRT +: NCH];
                    cru_route <= bus_wdata[B_CRURT +: NCH];
                end
                W_HOT_DBC: hot_dbc    <= bus_wdata[DBC_W-1:0];
                W_SHT_DBC: shut_dbc   <= bus_wdata[DBC_W-1:0];
                W_PER:     period     <= bus_wdata[PER_W-1:0];
                W_PER_HOT: period_hot <= bus_wdata[PER_W-1:0];
                default: ;
            endcase
        end
    end

    // sticky last-trip flag: set by a routed trip, survives rst_n
    always_ff @(posedge clk) begin
        if (!por_n) begin
            last_flag <= 1'b0;
        end else if (trip_log) begin
            last_flag <= 1'b1;
        end else if (wr_en && int'(widx) == W_CTRL && bus_wdata[B_LAST]) begin
            last_flag <= 1'b0;
        end
    end

    // one set of limit and data registers per channel
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        // limits are software-written; data comes only from samples
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hot_thr[g]  <= '0;
                shut_thr[g] <= '0;
                data_q[g]   <= '0;
            end else begin
                if (wr_en && int'(widx) == W_HOT + g) begin
                    hot_thr[g] <= bus_wdata[CODE_W-1:0];
                end
                if (wr_en && int'(widx) == W_SHUT + g) begin
                    shut_thr[g] <= bus_wdata[CODE_W-1:0];
                end
                if (smp_vld && int'(smp_ch) == g) begin
                    data_q[g] <= smp_code;
                end
            end
        end
    end

    // read multiplexer, zero for anything unmapped
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (int'(widx))
                W_CTRL: begin
                    bus_rdata[B_AUTO]         = auto_en;
                    bus_rdata[B_SRC +: NCH]   = src_en;
                    bus_rdata[B_POL]          = pol;
                    bus_rdata[B_LAST]         = last_flag;
                end
                W_ROUTE: begin
                    bus_rdata[B_PINRT +: NCH] = pin_route;
                    bus_rdata[B_CRURT +: NCH] = cru_route;
                end
                W_HOT_DBC: bus_rdata = {{DPAD{1'b0}}, hot_dbc};
                W_SHT_DBC: bus_rdata = {{DPAD{1'b0}}, shut_dbc};
                W_PER:     bus_rdata = {{PPAD{1'b0}}, period};
                W_PER_HOT: bus_rdata = {{PPAD{1'b0}}, period_hot};
                default: ;
            endcase
            for (int i = 0; i < NCH; i++) begin
                if (int'(widx) == W_DATA + i) bus_rdata = {{CPAD{1'b0}}, data_q[i]};
                if (int'(widx) == W_HOT + i)  bus_rdata = {{CPAD{1'b0}}, hot_thr[i]};
                if (int'(widx) == W_SHUT + i) bus_rdata = {{CPAD{1'b0}}, shut_thr[i]};
            end
        end
    end
endmodule

// File: rtl/tt_sched.sv
// Module: sampling scheduler.
// Counts tick strobes up to the active period, then walks the enabled
// channels in ascending order, one converter handshake each.
// Assumes the converter answers each held request with a one-cycle ack.
module tt_sched
    import tt_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int PER_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               auto_en,
    input  logic [NCH-1:0]     src_en,
    input  logic               any_hot,
    input  logic [PER_W-1:0]   period,
    input  logic [PER_W-1:0]   period_hot,
    output logic               adc_req,
    output logic [1:0]         adc_ch,
    input  logic               adc_ack,
    input  logic [CODE_W-1:0]  adc_code,
    output logic               smp_vld,
    output logic [1:0]         smp_ch,
    output logic [CODE_W-1:0]  smp_code
);
    sched_state_e       state;
    logic [PER_W-1:0]   cnt;
    logic [PER_W:0]     cnt_inc;
    logic [PER_W-1:0]   limit;
    logic [2:0]         pick_first;
    logic [2:0]         pick_next;

    // lowest enabled channel at or above a start index: {found, index}
    function automatic logic [2:0] first_en(input logic [NCH-1:0] en,
                                            input logic [2:0] from);
        logic [2:0] r;
        r = 3'b000;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (en[i] && (3'(i) >= from)) r = {1'b1, 2'(i)};
        end
        return r;
    endfunction

    assign limit      = any_hot ? period_hot : period;
    assign cnt_inc    = {1'b0, cnt} + 1'b1;
    assign pick_first = first_en(src_en, 3'd0);
    assign pick_next  = first_en(src_en, {1'b0, adc_ch} + 3'd1);
    assign adc_req    = (state == SCH_REQ);

    // round sequencing and period counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SCH_IDLE;
            cnt      <= '0;
            adc_ch   <= '0;
            smp_vld  <= 1'b0;
            smp_ch   <= '0;
            smp_code <= '0;
        end else begin
            smp_vld <= 1'b0;
            if (!auto_en) begin
                state <= SCH_IDLE;
                cnt   <= '0;
            end else if (state == SCH_IDLE) begin
                if (tick) begin
                    if (cnt_inc >= {1'b0, limit}) begin
                        cnt <= '0;
                        if (pick_first[2]) begin
                            state  <= SCH_REQ;
                            adc_ch <= pick_first[1:0];
                        end
                    end else begin
                        cnt <= cnt_inc[PER_W-1:0];
                    end
                end
            end else if (adc_ack) begin
                smp_vld  <= 1'b1;
                smp_ch   <= adc_ch;
                smp_code <= adc_code;
                if (pick_next[2]) begin
                    adc_ch <= pick_next[1:0];
                end else begin
                    state <= SCH_IDLE;
                end
            end
        end
    end
endmodule

// File: rtl/tt_chan.sv
// Module: per-channel limit watcher.
// Two saturating run counters: one for the hot limit (drives the hot
// flag), one for the shutdown limit (fires a one-time trip event).
// Assumes a lower code means a hotter die.
module tt_chan #(
    parameter int CODE_W = 12,
    parameter int DBC_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit,
    input  logic [CODE_W-1:0]  code,
    input  logic [CODE_W-1:0]  hot_thr,
    input  logic [CODE_W-1:0]  shut_thr,
    input  logic [DBC_W-1:0]   hot_dbc,
    input  logic [DBC_W-1:0]   shut_dbc,
    output logic               hot,
    output logic               trip_evt
);
    logic [DBC_W-1:0] hot_run;
    logic [DBC_W-1:0] shut_run;
    logic [DBC_W-1:0] hot_nxt;
    logic [DBC_W-1:0] shut_nxt;
    logic             over_hot;
    logic             over_shut;
    logic             tripped;

    assign over_hot  = (code <= hot_thr);
    assign over_shut = (code <= shut_thr);
    assign hot_nxt   = !over_hot  ? '0 : (hot_run  >= hot_dbc)  ? hot_run  : hot_run  + 1'b1;
    assign shut_nxt  = !over_shut ? '0 : (shut_run >= shut_dbc) ? shut_run : shut_run + 1'b1;
    assign trip_evt  = hit && over_shut && (shut_nxt >= shut_dbc) && !tripped;

    // run counters, hot flag and trip memory update on each own sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hot_run  <= '0;
            shut_run <= '0;
            hot      <= 1'b0;
            tripped  <= 1'b0;
        end else if (hit) begin
            hot_run  <= hot_nxt;
            shut_run <= shut_nxt;
            hot      <= over_hot && (hot_nxt >= hot_dbc);
            if (trip_evt) tripped <= 1'b1;
        end
    end
endmodule

// File: rtl/tt_outgate.sv
// Module: output gating.
// Routes channel trip events to the controller pulse and the sticky
// external pin, and applies the pin polarity.
// Assumes trip events are single-cycle.
module tt_outgate
    import tt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  trip_evt,
    input  logic [NCH-1:0]  pin_route,
    input  logic [NCH-1:0]  cru_route,
    input  logic            pol,
    output logic            cru_shut,
    output logic            pin_act,
    output logic            shut_pin,
    output logic            trip_log
);
    assign trip_log = |(trip_evt & (pin_route | cru_route));
    assign shut_pin = pol ? pin_act : ~pin_act;

    // controller pulse and sticky pin request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cru_shut <= 1'b0;
            pin_act  <= 1'b0;
        end else begin
            cru_shut <= |(trip_evt & cru_route);
            pin_act  <= pin_act | (|(trip_evt & pin_route));
        end
    end
endmodule

// File: rtl/thermtrip_monitor.sv
// Module: top of the thermal trip supervisor.
// Ties the register file, scheduler, four channel watchers and output
// gating together. Assumes an external divider supplies the tick strobe.
module thermtrip_monitor
    import tt_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int DBC_W  = 8,
    parameter int PER_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_n,
    input  logic               tick,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               adc_req,
    output logic [1:0]         adc_ch,
    input  logic               adc_ack,
    input  logic [CODE_W-1:0]  adc_code,
    output logic               cru_shut,
    output logic               shut_pin
);
    logic                        auto_en;
    logic [NCH-1:0]              src_en;
    logic                        pol;
    logic [NCH-1:0]              pin_route;
    logic [NCH-1:0]              cru_route;
    logic [NCH-1:0][CODE_W-1:0]  hot_thr;
    logic [NCH-1:0][CODE_W-1:0]  shut_thr;
    logic [DBC_W-1:0]            hot_dbc;
    logic [DBC_W-1:0]            shut_dbc;
    logic [PER_W-1:0]            period;
    logic [PER_W-1:0]            period_hot;
    logic                        last_flag;
    logic                        smp_vld;
    logic [1:0]                  smp_ch;
    logic [CODE_W-1:0]           smp_code;
    logic [NCH-1:0]              hot_vec;
    logic [NCH-1:0]              trip_vec;
    logic                        trip_log;
    logic                        pin_act;

    tt_regs #(.CODE_W(CODE_W), .DBC_W(DBC_W), .PER_W(PER_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .smp_vld(smp_vld), .smp_ch(smp_ch), .smp_code(smp_code),
        .trip_log(trip_log),
        .auto_en(auto_en), .src_en(src_en), .pol(pol),
        .pin_route(pin_route), .cru_route(cru_route),
        .hot_thr(hot_thr), .shut_thr(shut_thr),
        .hot_dbc(hot_dbc), .shut_dbc(shut_dbc),
        .period(period), .period_hot(period_hot),
        .last_flag(last_flag)
    );

    tt_sched #(.CODE_W(CODE_W), .PER_W(PER_W)) u_sched (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .auto_en(auto_en), .src_en(src_en), .any_hot(|hot_vec),
        .period(period), .period_hot(period_hot),
        .adc_req(adc_req), .adc_ch(adc_ch),
        .adc_ack(adc_ack), .adc_code(adc_code),
        .smp_vld(smp_vld), .smp_ch(smp_ch), .smp_code(smp_code)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_watch
        tt_chan #(.CODE_W(CODE_W), .DBC_W(DBC_W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .hit(smp_vld && int'(smp_ch) == g),
            .code(smp_code),
            .hot_thr(hot_thr[g]), .shut_thr(shut_thr[g]),
            .hot_dbc(hot_dbc), .shut_dbc(shut_dbc),
            .hot(hot_vec[g]), .trip_evt(trip_vec[g])
        );
    end

    tt_outgate u_out (
        .clk(clk), .rst_n(rst_n),
        .trip_evt(trip_vec), .pin_route(pin_route), .cru_route(cru_route),
        .pol(pol), .cru_shut(cru_shut), .pin_act(pin_act),
        .shut_pin(shut_pin), .trip_log(trip_log)
    );
endmodule

// File: rtl/tt_checker.sv
// Module: assertion checker for the thermal trip supervisor, bound to
// the top. Observes handshake, routing and sticky state over time.
module tt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        por_n,
    input logic        auto_en,
    input logic [3:0]  src_en,
    input logic        adc_req,
    input logic        adc_ack,
    input logic [1:0]  adc_ch,
    input logic        smp_vld,
    input logic        cru_shut,
    input logic        pin_act,
    input logic        last_flag
);
    // R4: a request is held with a stable channel until acknowledged
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && !adc_ack && auto_en) |=> (adc_req && $stable(adc_ch)));

    // R4: only enabled channels are requested
    p_req_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req |-> src_en[adc_ch]);

    // R4: a stored sample always follows a converter acknowledge
    p_smp_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |-> $past(adc_ack));

    // R10: the pin request is sticky until reset
    p_pin_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pin_act |=> pin_act);

    // R11: a controller pulse always comes with the last-trip flag set
    p_pulse_flag_r11: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        cru_shut |-> last_flag);

    // R12: turning auto mode off stops requests on the next cycle
    p_off_no_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> !adc_req);
endmodule

bind thermtrip_monitor tt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .auto_en(auto_en), .src_en(src_en),
    .adc_req(adc_req), .adc_ack(adc_ack), .adc_ch(adc_ch),
    .smp_vld(smp_vld), .cru_shut(cru_shut),
    .pin_act(pin_act), .last_flag(last_flag)
);

// File: tb/test_thermtrip_monitor.sv
`timescale 1ns/1ps
module test_thermtrip_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        tick = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        adc_req;
    logic [1:0]  adc_ch;
    logic        adc_ack = 1'b0;
    logic [11:0] adc_code = '0;
    logic        cru_shut;
    logic        shut_pin;

    logic [11:0] model [4] = '{12'd0, 12'd0, 12'd0, 12'd0};
    int total = 0;
    int bad = 0;
    int cru_cnt = 0;

    // stimulus/expectation table: channel, code, shutdown limit, trips?
    localparam int NV = 6;
    localparam int          V_CH   [NV] = '{1, 2, 0, 3, 1, 2};
    localparam logic [11:0] V_CODE [NV] = '{12'd3421, 12'd3437, 12'd3438, 12'd0, 12'd4095, 12'd1000};
    localparam logic [11:0] V_THR  [NV] = '{12'd3437, 12'd3437, 12'd3437, 12'd0, 12'd4095, 12'd999};
    localparam logic        V_TRIP [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

    thermtrip_monitor i_thermtrip_monitor (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick(tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .adc_req(adc_req), .adc_ch(adc_ch), .adc_ack(adc_ack), .adc_code(adc_code),
        .cru_shut(cru_shut), .shut_pin(shut_pin)
    );

    initial forever #5 clk = ~clk;

    // converter model: answers a pending request one cycle later
    initial forever begin
        @(negedge clk);
        if (adc_req && !adc_ack) begin
            adc_ack  = 1'b1;
            adc_code = model[adc_ch];
        end else begin
            adc_ack  = 1'b0;
        end
    end

    // controller pulse counter, sampled just after each edge
    initial forever begin
        @(posedge clk); #1;
        if (cru_shut) cru_cnt++;
    end

    initial begin
        #1_500_000;
        bad++; total++;
        $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic do_reset(input logic power);
        @(negedge clk);
        rst_n = 1'b0;
        if (power) por_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        @(negedge clk);
        cru_cnt = 0;
    endtask

    task automatic wait_acks(input int n);
        int k = 0;
        while (k < n) begin
            @(posedge clk); #1;
            if (adc_ack) k++;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // returns the channel of the next newly issued request
    task automatic next_req(output logic [1:0] ch);
        logic p_req = adc_req;
        logic p_ack = adc_ack;
        forever begin
            @(posedge clk); #1;
            if (adc_req && (!p_req || p_ack)) break;
            p_req = adc_req; p_ack = adc_ack;
        end
        ch = adc_ch;
    endtask

    // cycles between two successive request starts
    task automatic gap(output int g);
        logic [1:0] c;
        int t;
        next_req(c);
        t = 0;
        fork
            forever begin @(posedge clk); t++; end
        join_none
        next_req(c);
        disable fork;
        g = t;
    endtask

    initial begin
        logic [31:0] d;
        logic [1:0]  c;
        int          g;

        do_reset(1'b1);

        // R1: reset state
        rd(8'h04, d); check("R1 control after reset", d, 32'h0);
        rd(8'h44, d); check("R1 limit after reset", d, 32'h0);
        check("R1 pin inactive high", {31'b0, shut_pin}, 32'h1);
        check("R1 no pulse", {31'b0, cru_shut}, 32'h0);

        // R2: register readback
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); check("R2 routing fields", d, 32'h0000_0FF0);
        wr(8'h34, 32'h0000_0ABC); rd(8'h34, d); check("R2 hot limit ch1", d, 32'h0ABC);
        wr(8'h4C, 32'hFFFF_F123); rd(8'h4C, d); check("R2 shutdown limit ch3", d, 32'h0123);
        wr(8'h60, 32'h0000_0105); rd(8'h60, d); check("R2 hot debounce", d, 32'h05);
        wr(8'h6C, 32'h0001_2345); rd(8'h6C, d); check("R2 hot period", d, 32'h2345);
        wr(8'h04, 32'h0100_01F0); rd(8'h04, d); check("R2 control fields", d, 32'h0000_01F0);

        // R3: reserved offsets, unaligned addresses and read-only data
        wr(8'h10, 32'hDEAD_BEEF); rd(8'h10, d); check("R3 reserved 0x10", d, 32'h0);
        wr(8'h50, 32'h1234_5678); rd(8'h50, d); check("R3 reserved 0x50", d, 32'h0);
        wr(8'h35, 32'h0000_0111); rd(8'h34, d); check("R3 unaligned write ignored", d, 32'h0ABC);
        wr(8'h24, 32'h0000_0777); rd(8'h24, d); check("R3 data read-only", d, 32'h0);

        // R5, R9, R10: table of compare cases, one sample each
        for (int v = 0; v < NV; v++) begin
            do_reset(1'b1);
            model[V_CH[v]] = V_CODE[v];
            wr(8'h40 + 8'(4 * V_CH[v]), {20'b0, V_THR[v]});
            wr(8'h08, 32'h0000_0FF0);
            wr(8'h68, 32'd3);
            wr(8'h04, 32'h1 | (32'h10 << V_CH[v]));
            wait_acks(2);
            idle(3);
            check($sformatf("R5 vec%0d pin", v), {31'b0, shut_pin}, V_TRIP[v] ? 32'h0 : 32'h1);
            check($sformatf("R9 vec%0d pulse count", v), cru_cnt, V_TRIP[v] ? 32'd1 : 32'd0);
            rd(8'h20 + 8'(4 * V_CH[v]), d);
            check($sformatf("R4 vec%0d data reg", v), d, {20'b0, V_CODE[v]});
        end

        // R6: debounce of four, broken run restarts the count
        do_reset(1'b1);
        model[0] = 12'd4000;
        wr(8'h40, 32'd3437); wr(8'h64, 32'd4); wr(8'h68, 32'd8);
        wr(8'h08, 32'h0000_0110);
        wr(8'h04, 32'h0000_0011);
        wait_acks(1); idle(3);
        begin
            logic [11:0] seq [7] = '{12'd3421, 12'd3421, 12'd3437, 12'd3500,
                                     12'd3000, 12'd3000, 12'd3000};
            for (int s = 0; s < 7; s++) begin
                model[0] = seq[s];
                wait_acks(1); idle(3);
                check($sformatf("R6 no early trip step%0d", s), {31'b0, shut_pin}, 32'h1);
            end
        end
        wait_acks(1); idle(3);
        check("R6 trip on fourth in a row", {31'b0, shut_pin}, 32'h0);
        check("R9 one pulse at trip", cru_cnt, 32'd1);
        model[0] = 12'd4000;
        wait_acks(4); idle(3);
        check("R9 still one pulse", cru_cnt, 32'd1);
        check("R10 pin held after cooling", {31'b0, shut_pin}, 32'h0);

        // R11: flag survives system reset, clears by write of one
        rd(8'h04, d); check("R11 flag set after trip", d[24], 1'b1);
        do_reset(1'b0);
        check("R10 pin released by reset", {31'b0, shut_pin}, 32'h1);
        rd(8'h04, d); check("R11 flag survives rst_n", d, 32'h0100_0000);
        wr(8'h04, 32'h0100_0000); rd(8'h04, d); check("R11 write one clears", d, 32'h0);

        // R10: active-high pin polarity, then R11 power-on reset clears flag
        model[2] = 12'd100;
        wr(8'h48, 32'd3437); wr(8'h68, 32'd3); wr(8'h08, 32'h0000_0040);
        wr(8'h04, 32'h0000_0141);
        idle(1);
        check("R10 active-high idle low", {31'b0, shut_pin}, 32'h0);
        wait_acks(1); idle(3);
        check("R10 active-high asserted", {31'b0, shut_pin}, 32'h1);
        check("R9 no pulse when not routed", cru_cnt, 32'd0);
        do_reset(1'b1);
        rd(8'h04, d); check("R11 power-on reset clears flag", d, 32'h0);

        // R9, R10, R11: unrouted trip has no visible effect
        model[0] = 12'd100;
        wr(8'h40, 32'd3437); wr(8'h68, 32'd3);
        wr(8'h04, 32'h0000_0011);
        wait_acks(2); idle(3);
        check("R10 unrouted pin", {31'b0, shut_pin}, 32'h1);
        check("R9 unrouted pulse", cru_cnt, 32'd0);
        rd(8'h04, d); check("R11 unrouted flag", d[24], 1'b0);

        // R4: ascending order, skipped channels untouched
        do_reset(1'b1);
        model[0] = 12'd11; model[1] = 12'd2222; model[2] = 12'd33; model[3] = 12'd3333;
        wr(8'h68, 32'd2);
        wr(8'h04, 32'h0000_00A1);
        for (int r = 0; r < 4; r++) begin
            next_req(c);
            check($sformatf("R4 order step%0d", r), {30'b0, c}, (r % 2 == 0) ? 32'd1 : 32'd3);
        end
        wr(8'h04, 32'h0);
        rd(8'h20, d); check("R4 ch0 skipped", d, 32'h0);
        rd(8'h28, d); check("R4 ch2 skipped", d, 32'h0);
        rd(8'h24, d); check("R4 ch1 sampled", d, 32'd2222);
        rd(8'h2C, d); check("R4 ch3 sampled", d, 32'd3333);

        // R7, R8: normal and hot sampling periods
        do_reset(1'b1);
        model[0] = 12'd2500;
        wr(8'h30, 32'd2000); wr(8'h40, 32'd1000);
        wr(8'h60, 32'd2); wr(8'h68, 32'd20); wr(8'h6C, 32'd5);
        wr(8'h04, 32'h0000_0011);
        wait_acks(2);
        gap(g); check("R7 normal gap", g, 32'd21);
        model[0] = 12'd1500;
        wait_acks(4);
        gap(g); check("R8 hot gap", g, 32'd6);
        model[0] = 12'd2500;
        wait_acks(2);
        gap(g); check("R8 back to normal gap", g, 32'd21);

        // R12: auto mode off means no requests
        do_reset(1'b1);
        wr(8'h68, 32'd1);
        wr(8'h04, 32'h0000_00F0);
        begin
            int reqs = 0;
            for (int k = 0; k < 60; k++) begin
                @(posedge clk); #1;
                if (adc_req) reqs++;
            end
            check("R12 no request while off", reqs, 32'd0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule